// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Fractional Stop Length

This block is a full-duplex asynchronous serial port meant for host register access. The transmitter turns one byte into a frame on its serial output. The receiver rebuilds bytes from its serial input. A frame is built in this order: a single low start bit, eight data bits sent least significant bit first, an optional parity bit, and then a high stop interval. The stop interval can be one, one and a half, or two bit times long. All bit timing comes from one shared oversampling tick. The tick runs at sixteen times the bit rate, so a half bit is exactly eight ticks.

Bytes enter and leave through valid/ready handshakes. A transmit byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low for the whole frame, which gives the natural back-pressure. On the receive side there is a single holding register. `rx_valid` rises when a byte lands, and `rx_valid` and `rx_data` hold steady until a cycle in which `rx_ready` is high. The receiver does not wait for the consumer. If a new frame completes while the holding register is still full, the new byte is discarded and a sticky overrun flag is raised.

The divisor, parity and stop-length inputs are plain levels. The transmitter captures them when it accepts a byte. The receiver uses their live values. The receiver judges framing on the first stop bit only, whatever stop length is configured. The error flags are sticky until reset.

Top module: `serial_link_uart`

## Requirements
- R1: After reset `txd` is high, `tx_ready` is 1, `rx_valid` is 0, and all three error flags are 0.
- R2: One oversample tick occurs every `cfg_div` clock cycles, where a value of 0 acts as 1. Each start, data and parity bit lasts exactly 16 ticks.
- R3: A byte is accepted on an edge where `tx_valid` and `tx_ready` are both high. From the next cycle, `txd` carries the start bit (0), then data bits 0 to 7, then the parity bit if enabled, then stop (1). `tx_ready` is 0 from the cycle after acceptance until the stop interval ends. `txd` is 1 whenever `tx_ready` is 1.
- R4: `cfg_par_en`=1 inserts one parity bit. With `cfg_par_odd`=0 the bit equals the XOR of the eight data bits (even parity). With `cfg_par_odd`=1 it equals its inverse (odd parity).
- R5: `cfg_stop` selects the stop length: 2'b00 gives 16 ticks, 2'b01 gives 24 ticks, and 2'b10 or 2'b11 give 32 ticks. The receiver accepts every setting with either parity setting.
- R6: The transmitter uses the divisor value that is live at each tick. It uses the parity and stop settings captured at acceptance, so changing them mid-frame does not alter that frame.
- R7: A low pulse on `rxd` that has ended by 8 ticks after it was detected starts no frame.
- R8: The receiver samples each bit at its middle and presents the byte on `rx_valid`/`rx_data`. The byte stays unchanged until the consumer takes it with `rx_ready`=1.
- R9: With parity enabled, a received parity bit that does not match sets `err_parity`, which stays set until reset. The byte is still delivered.
- R10: A low level at the middle of the first stop bit sets `err_frame`, which stays set until reset. The byte is still delivered.
- R11: A frame that completes while `rx_valid` is 1 and `rx_ready` is 0 sets `err_overrun`, which stays set until reset. The new byte is dropped and the held byte is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 16 | Clock cycles per oversample tick |
| cfg_par_en | input | 1 | Insert or expect a parity bit |
| cfg_par_odd | input | 1 | 0 even parity, 1 odd parity |
| cfg_stop | input | 2 | Stop length select |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter idle and able to take a byte |
| tx_data | input | 8 | Byte to send |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, asynchronous |
| rx_valid | output | 1 | Received byte held |
| rx_ready | input | 1 | Consumer takes the held byte |
| rx_data | output | 8 | Received byte |
| err_parity | output | 1 | Sticky parity mismatch |
| err_frame | output | 1 | Sticky first-stop-bit low |
| err_overrun | output | 1 | Sticky byte-dropped flag |

## Verification
The hardest cases to reach from the ports are on the receive side: a short start glitch, a completed frame arriving while the holding register is full, and frames with corrupted parity or stop bits. The transmitter can never produce any of these. To reach them, the bench stops looping `txd` back and drives `rxd` itself. It forms short pulses, wrong parity bits and low stop bits at a bit period it chooses. It holds `rx_ready` low across two whole frames to force the overrun. A reset between the error cases keeps each sticky flag separately observable.

// File: rtl/sluart_pkg.sv
package sluart_pkg;
  localparam int OVS      = 16;
  localparam int TCNT_W   = 6;
  localparam int BYTE_W   = 8;

  typedef enum logic [2:0] {
    TS_IDLE, TS_START, TS_DATA, TS_PAR, TS_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    RS_IDLE, RS_START, RS_DATA, RS_PAR, RS_STOP
  } rx_state_e;

  function automatic logic [TCNT_W-1:0] stop_ticks(input logic [1:0] sel);
    case (sel)
      2'b00:   stop_ticks = TCNT_W'(OVS);
      2'b01:   stop_ticks = TCNT_W'(OVS + OVS/2);
      default: stop_ticks = TCNT_W'(2*OVS);
    endcase
  endfunction
endpackage

// File: rtl/sluart_tick.sv
module sluart_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  always_comb begin
    lim  = (div == '0) ? '0 : div - 1'b1;
    tick = (cnt_q >= lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sluart_tx.sv
module sluart_tx
  import sluart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [1:0]        stop_sel,
  input  logic              valid,
  output logic              ready,
  input  logic [BYTE_W-1:0] data,
  output logic              line
);
  tx_state_e         st_q;
  logic [TCNT_W-1:0] tcnt_q, lim_q, lim;
  logic [2:0]        idx_q;
  logic [BYTE_W-1:0] sh_q;
  logic              parb_q, pen_q, line_q;
  logic              seg_end;

  always_comb begin
    lim     = (st_q == TS_STOP) ? lim_q : TCNT_W'(OVS);
    seg_end = tick && (tcnt_q == lim - 1'b1);
    ready   = (st_q == TS_IDLE);
    line    = line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TS_IDLE;
      tcnt_q <= '0;
      lim_q  <= TCNT_W'(OVS);
      idx_q  <= '0;
      sh_q   <= '0;
      parb_q <= 1'b0;
      pen_q  <= 1'b0;
      line_q <= 1'b1;
    end else if (st_q == TS_IDLE) begin
      line_q <= 1'b1;
      if (valid) begin
        sh_q   <= data;
        parb_q <= (^data) ^ par_odd;
        pen_q  <= par_en;
        lim_q  <= stop_ticks(stop_sel);
        tcnt_q <= '0;
        st_q   <= TS_START;
        line_q <= 1'b0;
      end
    end else if (tick) begin
      if (!seg_end) begin
        tcnt_q <= tcnt_q + 1'b1;
      end else begin
        tcnt_q <= '0;
        case (st_q)
          TS_START: begin
            st_q   <= TS_DATA;
            idx_q  <= '0;
            line_q <= sh_q[0];
            sh_q   <= sh_q >> 1;
          end
          TS_DATA: begin
            if (idx_q == 3'd7) begin
              st_q   <= pen_q ? TS_PAR : TS_STOP;
              line_q <= pen_q ? parb_q : 1'b1;
            end else begin
              idx_q  <= idx_q + 1'b1;
              line_q <= sh_q[0];
              sh_q   <= sh_q >> 1;
            end
          end
          TS_PAR: begin
            st_q   <= TS_STOP;
            line_q <= 1'b1;
          end
          default: begin
            st_q   <= TS_IDLE;
            line_q <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sluart_rx.sv
module sluart_rx
  import sluart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              line,
  output logic              done,
  output logic [BYTE_W-1:0] byte_o,
  output logic              perr,
  output logic              ferr
);
  localparam logic [TCNT_W-1:0] HALF_M1 = TCNT_W'(OVS/2 - 1);
  localparam logic [TCNT_W-1:0] FULL_M1 = TCNT_W'(OVS - 1);

  rx_state_e         st_q;
  logic              s1_q, s2_q;
  logic [TCNT_W-1:0] cnt_q;
  logic [2:0]        idx_q;
  logic [BYTE_W-1:0] sh_q;
  logic              parb_q;
  logic              par_bad;
  logic              done_q, perr_q, ferr_q;
  logic [BYTE_W-1:0] byte_q;

  always_comb begin
    par_bad = par_en && (parb_q != ((^sh_q) ^ par_odd));
    done    = done_q;
    byte_o  = byte_q;
    perr    = perr_q;
    ferr    = ferr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= line;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      parb_q <= 1'b0;
      done_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      byte_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (tick) begin
        case (st_q)
          RS_IDLE: begin
            if (!s2_q) begin
              st_q  <= RS_START;
              cnt_q <= '0;
            end
          end
          RS_START: begin
            if (cnt_q == HALF_M1) begin
              cnt_q <= '0;
              idx_q <= '0;
              st_q  <= s2_q ? RS_IDLE : RS_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RS_DATA: begin
            if (cnt_q == FULL_M1) begin
              cnt_q <= '0;
              sh_q  <= {s2_q, sh_q[BYTE_W-1:1]};
              idx_q <= idx_q + 1'b1;
              if (idx_q == 3'd7) st_q <= par_en ? RS_PAR : RS_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RS_PAR: begin
            if (cnt_q == FULL_M1) begin
              cnt_q  <= '0;
              parb_q <= s2_q;
              st_q   <= RS_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: begin
            if (cnt_q == FULL_M1) begin
              cnt_q  <= '0;
              st_q   <= RS_IDLE;
              done_q <= 1'b1;
              byte_q <= sh_q;
              perr_q <= par_bad;
              ferr_q <= !s2_q;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_link_uart.sv
module serial_link_uart
  import sluart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [1:0]        cfg_stop,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              txd,
  input  logic              rxd,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun
);
  logic              tick;
  logic              f_done, f_perr, f_ferr;
  logic [BYTE_W-1:0] f_byte;
  logic              hv_q, pe_q, fe_q, ov_q;
  logic [BYTE_W-1:0] hd_q;

  sluart_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick)
  );

  sluart_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .stop_sel(cfg_stop),
    .valid(tx_valid), .ready(tx_ready), .data(tx_data), .line(txd)
  );

  sluart_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .line(rxd),
    .done(f_done), .byte_o(f_byte), .perr(f_perr), .ferr(f_ferr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q <= 1'b0;
      hd_q <= '0;
      pe_q <= 1'b0;
      fe_q <= 1'b0;
      ov_q <= 1'b0;
    end else if (f_done) begin
      if (f_perr) pe_q <= 1'b1;
      if (f_ferr) fe_q <= 1'b1;
      if (hv_q && !rx_ready) begin
        ov_q <= 1'b1;
      end else begin
        hv_q <= 1'b1;
        hd_q <= f_byte;
      end
    end else if (hv_q && rx_ready) begin
      hv_q <= 1'b0;
    end
  end

  assign rx_valid    = hv_q;
  assign rx_data     = hd_q;
  assign err_parity  = pe_q;
  assign err_frame   = fe_q;
  assign err_overrun = ov_q;
endmodule

// File: rtl/serial_link_uart_chk.sv
module serial_link_uart_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        txd,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [7:0]  rx_data,
  input logic        err_parity,
  input logic        err_frame,
  input logic        err_overrun
);
  a_r3_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  a_r3_accept_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!txd && !tx_ready));

  a_r8_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  a_r9_parity_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity |=> err_parity);

  a_r10_frame_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame |=> err_frame);

  a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |=> err_overrun);

  a_r11_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(rx_valid && !rx_ready));
endmodule

bind serial_link_uart serial_link_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .txd(txd), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
);

// File: tb/serial_link_uart_tb.sv
`timescale 1ns/1ps
module serial_link_uart_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_div = 16'd4;
  logic        cfg_par_en = 1'b0;
  logic        cfg_par_odd = 1'b0;
  logic [1:0]  cfg_stop = 2'b00;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        loop = 1'b1;
  logic        drv = 1'b1;
  logic        rx_ready = 1'b1;
  logic        tx_ready, txd, rx_valid, err_parity, err_frame, err_overrun;
  logic [7:0]  rx_data;
  logic        rxd;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  assign rxd = loop ? txd : drv;

  always #2.5 clk = ~clk;

  serial_link_uart u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .txd(txd), .rxd(rxd),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference for the transmit line (R2 R3 R4 R5 R6)
  int  m_cnt;
  bit  m_busy;
  bit  m_line;
  int  m_rem;
  int  m_segs[$];
  int  rx_exp[$];

  always @(posedge clk) begin
    int lim;
    bit t;
    if (!rst_n) begin
      m_cnt = 0; m_busy = 0; m_line = 1; m_rem = 0; m_segs.delete();
    end else begin
      lim = (cfg_div == 0) ? 0 : int'(cfg_div) - 1;
      t = (m_cnt >= lim);
      m_cnt = t ? 0 : m_cnt + 1;
      if (m_busy) begin
        if (t) begin
          m_rem--;
          if (m_rem == 0) begin
            if (m_segs.size() == 0) begin
              m_busy = 0; m_line = 1;
            end else begin
              int s;
              s = m_segs.pop_front();
              m_line = (s >= 1000);
              m_rem = s % 1000;
            end
          end
        end
      end else if (tx_valid) begin
        for (int i = 0; i < 8; i++) m_segs.push_back(tx_data[i] * 1000 + 16);
        if (cfg_par_en) m_segs.push_back(((^tx_data) ^ cfg_par_odd) * 1000 + 16);
        m_segs.push_back(1000 + (cfg_stop == 2'b00 ? 16 : cfg_stop == 2'b01 ? 24 : 32));
        m_line = 0; m_rem = 16; m_busy = 1;
        if (loop) rx_exp.push_back(int'(tx_data));
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(txd === m_line, "R3 txd", int'(txd), int'(m_line));
      chk(tx_ready === !m_busy, "R3 tx_ready", int'(tx_ready), int'(!m_busy));
      if (loop && rx_ready && rx_valid) begin
        if (rx_exp.size() == 0) chk(0, "R8 unexpected byte", int'(rx_data), 0);
        else begin
          int e;
          e = rx_exp.pop_front();
          chk(rx_data === e[7:0], "R8 loopback byte", int'(rx_data), e);
        end
      end
    end
  end

  task automatic tx_send(input logic [7:0] d);
    tx_valid = 1'b1; tx_data = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic tx_drain();
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic rx_bit(input logic v);
    drv = v;
    repeat (16 * int'(cfg_div)) @(negedge clk);
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit bad_par, input logic stopv);
    rx_bit(1'b0);
    for (int i = 0; i < 8; i++) rx_bit(d[i]);
    if (cfg_par_en) rx_bit((^d) ^ cfg_par_odd ^ bad_par);
    rx_bit(stopv);
    rx_bit(1'b1);
    rx_bit(1'b1);
  endtask

  task automatic rx_pop();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(txd === 1'b1, "R1 txd", int'(txd), 1);
    chk(tx_ready === 1'b1, "R1 tx_ready", int'(tx_ready), 1);
    chk(rx_valid === 1'b0, "R1 rx_valid", int'(rx_valid), 0);
    chk({err_parity, err_frame, err_overrun} === 3'b000, "R1 flags",
        int'({err_parity, err_frame, err_overrun}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Loopback: R2 R3 R5, no parity, 1 stop
    tx_send(8'hA5);
    tx_drain();
    // R4 even parity with 1.5 stop, back-to-back
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_stop = 2'b01;
    tx_send(8'h3C);
    tx_send(8'h01);
    tx_drain();
    // R4 odd parity with 2 stop, R2 another divisor
    cfg_par_odd = 1'b1; cfg_stop = 2'b10; cfg_div = 16'd3;
    tx_send(8'h81);
    tx_send(8'hFE);
    tx_drain();
    // R5 code 3 acts as two stop bits, no parity
    cfg_par_en = 1'b0; cfg_stop = 2'b11; cfg_div = 16'd0;
    tx_send(8'h5B);
    tx_drain();
    cfg_div = 16'd4;
    chk(rx_exp.size() == 0, "R8 all loopback bytes received", rx_exp.size(), 0);

    // R6 config change mid-frame ignored by the frame in flight
    loop = 1'b0; cfg_stop = 2'b00; cfg_par_en = 1'b0;
    tx_send(8'hC7);
    cfg_stop = 2'b10; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
    tx_drain();
    cfg_stop = 2'b00; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;

    // Receive side driven directly
    do_reset();
    rx_ready = 1'b0;
    // R7 glitch rejected
    drv = 1'b0;
    repeat (12) @(negedge clk);
    drv = 1'b1;
    repeat (200) @(negedge clk);
    chk(rx_valid === 1'b0, "R7 glitch ignored", int'(rx_valid), 0);
    // R8 good frame held until taken
    rx_frame(8'h5A, 0, 1'b1);
    chk(rx_valid === 1'b1, "R8 rx_valid", int'(rx_valid), 1);
    chk(rx_data === 8'h5A, "R8 rx_data", int'(rx_data), 8'h5A);
    chk(err_parity === 1'b0, "R9 no parity error on good frame", int'(err_parity), 0);
    rx_pop();
    chk(rx_valid === 1'b0, "R8 taken", int'(rx_valid), 0);
    // R9 bad parity
    rx_frame(8'h13, 1, 1'b1);
    chk(rx_data === 8'h13, "R9 byte delivered", int'(rx_data), 8'h13);
    chk(err_parity === 1'b1, "R9 err_parity", int'(err_parity), 1);
    chk(err_frame === 1'b0, "R10 no frame error yet", int'(err_frame), 0);
    rx_pop();
    // R10 low stop bit
    rx_frame(8'h77, 0, 1'b0);
    chk(rx_data === 8'h77, "R10 byte delivered", int'(rx_data), 8'h77);
    chk(err_frame === 1'b1, "R10 err_frame", int'(err_frame), 1);
    chk(err_overrun === 1'b0, "R11 no overrun yet", int'(err_overrun), 0);
    rx_pop();

    // R11 overrun with odd parity and 1.5 stop (R4 R5 receive side)
    do_reset();
    rx_ready = 1'b0; cfg_par_odd = 1'b1; cfg_stop = 2'b01;
    rx_frame(8'hC3, 0, 1'b1);
    chk(err_parity === 1'b0, "R4 odd parity accepted", int'(err_parity), 0);
    rx_frame(8'h44, 0, 1'b1);
    chk(err_overrun === 1'b1, "R11 err_overrun", int'(err_overrun), 1);
    chk(rx_data === 8'hC3, "R11 held byte kept", int'(rx_data), 8'hC3);
    rx_pop();
    chk(rx_valid === 1'b0, "R11 dropped byte not delivered", int'(rx_valid), 0);
    chk(err_overrun === 1'b1, "R11 sticky", int'(err_overrun), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule